// File: doc/BRIEF.md
# Counter-Based Global Reset Sequencer

This block is the single place where a chip decides that all of its logic must restart. It runs on one wakeup clock and turns several reset causes into one repeatable sequence. The causes are a power-up shift register, the lock indicator of the clock generator (synchronized here), an external request that has already been debounced, and a restart request raised when lock is lost after the system has come out of reset. Any cause, even for a single cycle, clears a saturating counter. The master synchronous reset stays asserted until the counter has climbed back to its terminal value. Because of this, short bursts of activity on a cause never show up as toggling on the master reset.

A second output resets the PLL. It follows every cause except "not locked". A PLL that is waiting for lock therefore never holds itself in reset. If lock drops after release, the restart request asserts the PLL reset as well, so the whole system, PLL included, starts again. Every register starts in the state that pins the counter at zero. While the wakeup clock may still be running out of specification, only single-bit registers with a constant next value take part, and the counter cannot wander.

Top module: `rst_sequencer`

## Requirements
- R1: With lock high and no external request from configuration onward, the PLL reset is asserted through clock edge BOOT_LEN+1 and released after edge BOOT_LEN+2. The master reset is released after edge BOOT_LEN+TERM_COUNT+3. The power-up request is raised once and never returns.
- R2: An external request sampled high at edge k asserts the PLL reset after edge k+2, for as many cycles as the request was sampled high.
- R3: An external request sampled high at edge k while the master reset is released asserts the master reset after edge k+4. The master reset is released after edge k+4+TERM_COUNT, which is exactly TERM_COUNT cycles of reset.
- R4: A request that arrives while the counter is still counting restarts the count from zero. The master reset is released exactly TERM_COUNT+4 edges after the latest request edge and never earlier.
- R5: The lock input passes through two flip-flops. If lock is first sampled low at edge k, the master reset is asserted no later than after edge k+4 and stays asserted while lock stays low.
- R6: If lock is first sampled high again at edge m, the master reset is released after edge m+3+TERM_COUNT. Toggling lock while the master reset is asserted keeps it asserted without a gap.
- R7: A low lock input while the master reset is asserted never asserts the PLL reset.
- R8: If lock is first sampled low at edge k while the master reset is released, the PLL reset is asserted for min(d,3) cycles starting after edge k+2, where d is the number of edges at which lock is sampled low.
- R9: Before the first clock edge, the master reset and the PLL reset are both asserted.
- R10: Once the master reset is released and no cause is active, both outputs stay deasserted and the counter stays at its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wake | input | 1 | Wakeup clock; all state is clocked on its rising edge |
| lock_async | input | 1 | Active-high PLL lock indicator, asynchronous to clk_wake |
| ext_req | input | 1 | Active-high debounced external restart request |
| sys_rst | output | 1 | Master synchronous reset, active high |
| pll_rst | output | 1 | PLL reset, active high |

## Verification
Each result has a fixed latency from the edge at which a cause is first sampled. An external request shows up on the PLL reset two edges later and asserts the master reset four edges later. The master reset is released TERM_COUNT+4 edges after the last external request, or TERM_COUNT+3 edges after lock returns. At power-up the two release points are BOOT_LEN+2 and BOOT_LEN+TERM_COUNT+3. The bench counts rising edges itself. For each stimulus it records the edge at which the input is first sampled and derives the expected window of every output from these latencies. It then compares both outputs against those windows a quarter period after every edge. The windows are compared cycle by cycle, not just at the end points, so an early release, a late assertion or a one-cycle glitch are all reported.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int unsigned DEF_TERM_COUNT = 31;
    localparam int unsigned DEF_BOOT_LEN   = 16;

    // Bit positions of the causes inside the synchronized cause vector.
    typedef enum int unsigned {
        SRC_UNLOCK = 0,
        SRC_EXT    = 1
    } src_idx_e;

    localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/rst_cause_sync.sv
module rst_cause_sync #(
    parameter int unsigned W    = 2,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] src_o
);

    typedef struct packed {
        logic [W-1:0] stg1;
        logic [W-1:0] stg2;
    } sync_t;

    localparam sync_t POWERUP = '{stg1: INIT, stg2: INIT};

    sync_t sync_q = POWERUP;
    sync_t sync_d;

    always_comb begin
        sync_d      = sync_q;
        sync_d.stg1 = src_i;
        sync_d.stg2 = sync_q.stg1;
    end

    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign src_o = sync_q.stg2;

    logic [1:0] armed_q = 2'd0;
    always_ff @(posedge clk) begin
        if (armed_q != 2'd3) armed_q <= armed_q + 2'd1;
    end

    // R5: the cause leaves exactly two stages after it was sampled
    assert_sync_depth_R5: assert property (@(posedge clk)
        disable iff (armed_q < 2'd2)
        src_o == $past(src_i, 2));

endmodule

// File: rtl/rst_wake_shreg.sv
module rst_wake_shreg #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    output logic boot_req_o
);

    typedef struct packed {
        logic [LEN-1:0] fill;
        logic           req;
    } boot_t;

    localparam boot_t POWERUP = '{fill: '0, req: 1'b1};

    boot_t boot_q = POWERUP;
    boot_t boot_d;

    generate
        if (LEN > 1) begin : g_shift
            always_comb begin
                boot_d      = boot_q;
                boot_d.fill = {boot_q.fill[LEN-2:0], 1'b1};
                boot_d.req  = ~boot_q.fill[LEN-1];
            end
        end else begin : g_single
            always_comb begin
                boot_d      = boot_q;
                boot_d.fill = 1'b1;
                boot_d.req  = ~boot_q.fill[0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        boot_q <= boot_d;
    end

    assign boot_req_o = boot_q.req;

    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= 1'b1;

    // R1: once the power-up request has dropped it never returns
    assert_boot_once_R1: assert property (@(posedge clk)
        disable iff (!armed_q)
        !boot_req_o |=> !boot_req_o);

endmodule

// File: rtl/rst_seq_core.sv
module rst_seq_core #(
    parameter int unsigned TERM_COUNT = 31
) (
    input  logic clk,
    input  logic unlocked_i,
    input  logic ext_i,
    input  logic boot_i,
    output logic master_rst_o,
    output logic pll_rst_o
);

    localparam int unsigned CW = $clog2(TERM_COUNT + 1);
    localparam logic [CW-1:0] TERM = CW'(TERM_COUNT);
    localparam int unsigned RW = $clog2(TERM_COUNT + 2);
    localparam logic [RW-1:0] RUN_MAX = RW'(TERM_COUNT + 1);

    typedef struct packed {
        logic          clear;
        logic          pll;
        logic          master;
        logic [CW-1:0] cnt;
    } seq_t;

    localparam seq_t POWERUP = '{clear: 1'b1, pll: 1'b1, master: 1'b1, cnt: '0};

    seq_t seq_q = POWERUP;
    seq_t seq_d;

    logic restart;
    logic pll_causes;

    always_comb begin
        restart    = unlocked_i & ~seq_q.master;
        pll_causes = ext_i | boot_i | restart;

        seq_d        = seq_q;
        seq_d.clear  = unlocked_i | pll_causes;
        seq_d.pll    = pll_causes;
        seq_d.master = (seq_q.cnt != TERM);

        if (seq_q.clear) begin
            seq_d.cnt = '0;
        end else if (seq_q.cnt != TERM) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign master_rst_o = seq_q.master;
    assign pll_rst_o    = seq_q.pll;

    // Checker state: cycles since the clear register last went low.
    logic armed_q = 1'b0;
    logic [RW-1:0] run_q = '0;
    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
        if (seq_q.clear) run_q <= '0;
        else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end

    // R2: a sampled external request reaches the PLL reset
    assert_ext_to_pll_R2: assert property (@(posedge clk)
        disable iff (!armed_q)
        ext_i |=> pll_rst_o);

    // R3: master reset only drops after a full uninterrupted count
    assert_no_early_R3: assert property (@(posedge clk)
        disable iff (!armed_q)
        $fell(master_rst_o) |-> (run_q == RUN_MAX));

    // R4: an active clear always restarts the count from zero
    assert_clear_zero_R4: assert property (@(posedge clk)
        disable iff (!armed_q)
        seq_q.clear |=> (seq_q.cnt == '0));

    // R7: not-locked alone never resets the PLL while reset is held
    assert_pll_quiet_R7: assert property (@(posedge clk)
        disable iff (!armed_q)
        (master_rst_o && !ext_i && !boot_i) |=> !pll_rst_o);

    // R8: loss of lock after release resets the PLL
    assert_pll_restart_R8: assert property (@(posedge clk)
        disable iff (!armed_q)
        (unlocked_i && !master_rst_o) |=> pll_rst_o);

    // R10: the counter never passes its terminal value and holds there
    assert_cnt_bound_R10: assert property (@(posedge clk)
        disable iff (!armed_q)
        seq_q.cnt <= TERM);

    assert_cnt_hold_R10: assert property (@(posedge clk)
        disable iff (!armed_q)
        (seq_q.cnt == TERM && !seq_q.clear) |=> (seq_q.cnt == TERM));

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int unsigned TERM_COUNT = DEF_TERM_COUNT,
    parameter int unsigned BOOT_LEN   = DEF_BOOT_LEN
) (
    input  logic clk_wake,
    input  logic lock_async,
    input  logic ext_req,
    output logic sys_rst,
    output logic pll_rst
);

    logic [NUM_SRC-1:0] raw_src;
    logic [NUM_SRC-1:0] sync_src;
    logic               boot_req;

    always_comb begin
        raw_src             = '0;
        raw_src[SRC_UNLOCK] = ~lock_async;
        raw_src[SRC_EXT]    = ext_req;
    end

    rst_cause_sync #(
        .W    (NUM_SRC),
        .INIT ('1)
    ) u_sync (
        .clk   (clk_wake),
        .src_i (raw_src),
        .src_o (sync_src)
    );

    rst_wake_shreg #(
        .LEN (BOOT_LEN)
    ) u_boot (
        .clk        (clk_wake),
        .boot_req_o (boot_req)
    );

    rst_seq_core #(
        .TERM_COUNT (TERM_COUNT)
    ) u_core (
        .clk          (clk_wake),
        .unlocked_i   (sync_src[SRC_UNLOCK]),
        .ext_i        (sync_src[SRC_EXT]),
        .boot_i       (boot_req),
        .master_rst_o (sys_rst),
        .pll_rst_o    (pll_rst)
    );

    logic [2:0] armed_q = 3'd0;
    always_ff @(posedge clk_wake) begin
        if (armed_q != 3'd7) armed_q <= armed_q + 3'd1;
    end

    // R5: lock sampled low forces the master reset within four edges
    assert_lock_forces_rst_R5: assert property (@(posedge clk_wake)
        disable iff (armed_q < 3'd5)
        !$past(lock_async, 5) |-> sys_rst);

endmodule

// File: tb/rst_sequencer_tb_top.sv
module rst_sequencer_tb_top;

    localparam int TERM = 10;
    localparam int BOOT = 8;
    localparam int BIG  = 32'h7fffffff;

    logic clk = 1'b0;
    logic lock_async;
    logic ext_req;
    logic sys_rst;
    logic pll_rst;

    rst_sequencer #(
        .TERM_COUNT (TERM),
        .BOOT_LEN   (BOOT)
    ) dut_i (
        .clk_wake   (clk),
        .lock_async (lock_async),
        .ext_req    (ext_req),
        .sys_rst    (sys_rst),
        .pll_rst    (pll_rst)
    );

    initial forever #10 clk = ~clk;

    int    edge_n = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    mon_on = 1'b0;
    int    m_rise;
    int    m_fall;
    bit    p_map[int];
    string m_tag = "R1";
    string p_tag = "R1";

    always @(posedge clk) edge_n++;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at edge %0d: actual %0d expected %0d",
                     tag, what, edge_n, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Compare both outputs a quarter period after every rising edge.
    always @(posedge clk) begin
        #5;
        if (mon_on) begin
            bit em;
            bit ep;
            em = (edge_n >= m_rise) && (edge_n < m_fall);
            ep = p_map.exists(edge_n);
            chk(sys_rst == em, m_tag, "sys_rst", int'(sys_rst), int'(em));
            chk(pll_rst == ep, p_tag, "pll_rst", int'(pll_rst), int'(ep));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle external request; k is the edge that samples it.
    task automatic ext_pulse();
        int k;
        @(negedge clk);
        ext_req = 1'b1;
        k = edge_n + 1;
        p_map[k + 2] = 1'b1;
        if (edge_n >= m_fall) m_rise = k + 4;
        m_fall = k + 4 + TERM;
        @(negedge clk);
        ext_req = 1'b0;
    endtask

    // Lock low for dur sampling edges, then back high.
    task automatic lock_drop(input int dur);
        int k;
        int m;
        int hi;
        @(negedge clk);
        lock_async = 1'b0;
        k = edge_n + 1;
        if (edge_n >= m_fall) begin
            m_rise = k + 4;
            hi = (dur < 3) ? dur : 3;
            for (int j = 0; j < hi; j++) p_map[k + 2 + j] = 1'b1;
        end
        m_fall = BIG;
        repeat (dur - 1) @(negedge clk);
        @(negedge clk);
        lock_async = 1'b1;
        m = edge_n + 1;
        m_fall = m + 3 + TERM;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        lock_async = 1'b1;
        ext_req    = 1'b0;
        m_rise     = 0;
        m_fall     = BOOT + 3 + TERM;
        for (int e = 0; e < BOOT + 2; e++) p_map[e] = 1'b1;

        // R9: both resets asserted before any edge
        #1;
        chk(sys_rst == 1'b1, "R9", "sys_rst at time zero", int'(sys_rst), 1);
        chk(pll_rst == 1'b1, "R9", "pll_rst at time zero", int'(pll_rst), 1);
        mon_on = 1'b1;

        // R1: power-up sequence driven by the shift register
        idle(BOOT + TERM + 12);

        // R10: long quiet stretch after release
        m_tag = "R10"; p_tag = "R10";
        idle(40);

        // R2 / R3: isolated one-cycle requests from the released state
        m_tag = "R3"; p_tag = "R2";
        repeat (3) begin
            ext_pulse();
            idle(TERM + 10);
        end

        // R4: second request at every spacing that lands inside the count
        m_tag = "R4"; p_tag = "R2";
        for (int gap = 0; gap <= TERM - 2; gap++) begin
            ext_pulse();
            idle(gap);
            ext_pulse();
            idle(TERM + 10);
        end

        // R5 / R8: loss of lock after release, several dropout lengths
        m_tag = "R5"; p_tag = "R8";
        for (int dur = 1; dur <= 5; dur++) begin
            lock_drop(dur);
            idle(TERM + 10);
        end

        // R6 / R7: lock toggling while the master reset is held
        m_tag = "R6"; p_tag = "R7";
        ext_pulse();
        idle(5);
        lock_drop(2);
        idle(1);
        lock_drop(1);
        idle(3);
        lock_drop(4);
        idle(TERM + 10);

        m_tag = "R10"; p_tag = "R10";
        idle(20);

        mon_on = 1'b0;
        finish_run();
    end

endmodule